// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus (MDC clock plus bidirectional MDIO data). It runs Clause 22 frames. Each frame is a 32-bit preamble of ones, a start pattern, an opcode, a 5-bit PHY address, a 5-bit register number, a turnaround and 16 data bits. Software talks to the block through six 32-bit words. It first stores the PHY and register numbers. It then starts a write by storing the data word, or starts a read by raising the read bit of the command word.

MDC is made from the system clock by a programmable divider and toggles only while a frame runs. The controller drives MDIO for the header of every frame and for the whole of a write frame. It releases MDIO from the turnaround of a read onward and samples the returned bits on MDC rising edges. A busy flag and a separate not-valid flag let software tell when the bus is free again and when read data may be used. A soft-reset bit in the configuration word aborts a frame that is in progress.

Top module: `mdio_master`

## Requirements
- R1: Word 2 holds the target PHY number in bits 12:8 and the PHY register number in bits 4:0. Both fields are sent in every frame, MSB first, after the opcode.
- R2: A bus write to word 3 launches a write frame carrying bits 15:0 of the written value. The frame consists of 32 ones, start 01, opcode 01, PHY, register, turnaround 10, then the data MSB first. MDIO is driven for all 64 bits.
- R3: A read frame with opcode 10 launches only when a write to word 1 changes its bit 0 from 0 to 1. Writing 1 while bit 0 is already 1 starts no frame.
- R4: In a read frame MDIO is released from bit 46 (the first turnaround bit) to the end of the frame. The 16 bits sampled on MDC rising edges are returned in bits 15:0 of word 4, first received bit in bit 15.
- R5: Bit 0 of word 5 (busy) reads 1 from the clock after a launch until the frame ends, and reads 0 when idle.
- R6: Bit 2 of word 5 (not-valid) reads 1 from a read launch until the last data bit has been captured. It is never set by a write frame and is set only while busy is set.
- R7: Bits 2:0 of word 0 select n. The MDC high and low phases each last 4*(n+1) system clocks. When idle, MDC is low and MDIO is released.
- R8: A write to word 0 with bit 31 set aborts any frame on the next clock: busy and not-valid clear, MDIO is released and MDC is low. The clock-select field keeps its value.
- R9: After reset, word 0 reads 7, word 5 reads 0, MDC is low and MDIO is released.
- R10: While a frame runs, the driven MDIO value and its enable change only on a falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index (0 config, 1 command, 2 address, 3 write data, 4 read data, 5 indication) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the word selected by bus_addr |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 releases the line) |

## Verification
The bench models a PHY on the pins and captures every driven bit on MDC rising edges, so the checks hit the opcode, the field order and the turnaround. A design that swapped fields or opcodes would give a wrong captured frame. A design that drove through the turnaround would show too many driven bits. It rewrites the read bit as 1 without clearing it first; an edge detector that is level-sensitive would start a spurious frame there. It aborts a write mid-frame, so a soft reset that fails to clear busy or release the line is caught. It also measures the MDC half period at two divider settings, where an off-by-one count shows up as a wrong length.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;
    localparam int DATA_W     = 16;

    typedef enum logic [2:0] {
        RA_CFG   = 3'd0,
        RA_CMD   = 3'd1,
        RA_ADDR  = 3'd2,
        RA_WDATA = 3'd3,
        RA_RDATA = 3'd4,
        RA_IND   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e          op;
        logic [4:0]        phy;
        logic [4:0]        regn;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
        logic [1:0]        ta;
        logic [DATA_W-1:0] body;
        ta   = (r.op == OP_WRITE) ? 2'b10 : 2'b11;
        body = (r.op == OP_WRITE) ? r.wdata : '1;
        return {32'hFFFF_FFFF, 2'b01, r.op, r.phy, r.regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int SEL_W = 3,
    parameter int CNT_W = $clog2(4 * (2 ** SEL_W))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             mdc_q;
    logic             wrap;

    always_comb begin
        lim  = CNT_W'((32'(sel) + 32'd1) * 32'd4 - 32'd1);
        wrap = en && (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc      = mdc_q && en;
    assign rise_stb = wrap && !mdc_q;
    assign fall_stb = wrap && mdc_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              nv,
    input  logic [DATA_W-1:0] rd_data,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              abort,
    output logic              start,
    output mdio_req_t         req,
    output logic              cmd_bit
);
    logic [4:0]        phy_q;
    logic [4:0]        regn_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_cfg, wr_cmd, wr_addr, wr_data;
    logic              start_rd;

    always_comb begin
        wr_cfg   = bus_wr && (bus_addr == RA_CFG);
        wr_cmd   = bus_wr && (bus_addr == RA_CMD);
        wr_addr  = bus_wr && (bus_addr == RA_ADDR);
        wr_data  = bus_wr && (bus_addr == RA_WDATA);
        abort    = wr_cfg && bus_wdata[31];
        start_rd = wr_cmd && bus_wdata[0] && !cmd_bit;
        start    = start_rd || wr_data;
        req.op    = wr_data ? OP_WRITE : OP_READ;
        req.phy   = phy_q;
        req.regn  = regn_q;
        req.wdata = wr_data ? bus_wdata[DATA_W-1:0] : wdata_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sel <= '1;
            cmd_bit <= 1'b0;
            phy_q   <= '0;
            regn_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (wr_cfg && !bus_wdata[31]) clk_sel <= bus_wdata[SEL_W-1:0];
            if (wr_cmd)  cmd_bit <= bus_wdata[0];
            if (wr_addr) begin
                phy_q  <= bus_wdata[12:8];
                regn_q <= bus_wdata[4:0];
            end
            if (wr_data) wdata_q <= bus_wdata[DATA_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CFG:   bus_rdata[SEL_W-1:0] = clk_sel;
            RA_CMD:   bus_rdata[0] = cmd_bit;
            RA_ADDR:  bus_rdata = {19'd0, phy_q, 3'd0, regn_q};
            RA_WDATA: bus_rdata[DATA_W-1:0] = wdata_q;
            RA_RDATA: bus_rdata[DATA_W-1:0] = rd_data;
            RA_IND:   bus_rdata[2:0] = {nv, 1'b0, busy};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              nv,
    output logic              is_read,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame;
    logic [FRAME_BITS-1:0] shreg;
    logic [DATA_W-1:0]     rd_shift;
    logic [IDX_W-1:0]      idx_nxt;

    always_comb begin
        frame   = build_frame(req);
        idx_nxt = bit_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy    <= 1'b0;
            nv      <= 1'b0;
            is_read <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            nv      <= (req.op == OP_READ);
            is_read <= (req.op == OP_READ);
            bit_idx <= '0;
            shreg   <= frame;
            mdio_o  <= frame[FRAME_BITS-1];
            mdio_oe <= 1'b1;
        end else if (busy) begin
            if (rise_stb && is_read && bit_idx == LAST) nv <= 1'b0;
            if (fall_stb) begin
                if (bit_idx == LAST) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                end else begin
                    bit_idx <= idx_nxt;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                    mdio_o  <= shreg[FRAME_BITS-2];
                    mdio_oe <= !(is_read && idx_nxt >= IDX_W'(TA_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_shift <= '0;
            rd_data  <= '0;
        end else if (busy && is_read && rise_stb && bit_idx >= IDX_W'(DATA_IDX)) begin
            rd_shift <= {rd_shift[DATA_W-2:0], mdio_i};
            if (bit_idx == LAST) rd_data <= {rd_shift[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [SEL_W-1:0]  clk_sel;
    logic              abort, start, cmd_bit;
    mdio_req_t         req;
    logic              eng_busy, eng_nv, eng_is_read;
    logic [IDX_W-1:0]  eng_idx;
    logic [DATA_W-1:0] rd_data;
    logic              rise_stb, fall_stb;

    mdio_regs #(.SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(eng_busy),
        .nv(eng_nv), .rd_data(rd_data), .clk_sel(clk_sel), .abort(abort),
        .start(start), .req(req), .cmd_bit(cmd_bit)
    );

    mdio_clkgen #(.SEL_W(SEL_W)) clkgen_i (
        .clk(clk), .rst(rst), .en(eng_busy), .sel(clk_sel),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_engine engine_i (
        .clk(clk), .rst(rst), .abort(abort), .start(start), .req(req),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(eng_busy), .nv(eng_nv), .is_read(eng_is_read),
        .bit_idx(eng_idx), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             nv,
    input logic             fall_stb,
    input logic             cmd_bit,
    input logic             is_read,
    input logic [IDX_W-1:0] bit_idx
);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_write_launch_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_WDATA && !busy) |=> busy);

    assert_no_relaunch_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_CMD && bus_wdata[0] && cmd_bit && !busy) |=> !busy);

    assert_released_read_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && is_read && bit_idx >= IDX_W'(TA_IDX)) |-> !mdio_oe);

    assert_nv_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
        nv |-> busy);

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_CFG && bus_wdata[31]) |=> (!busy && !nv && !mdio_oe && !mdc));

    assert_fall_only_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(fall_stb)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk chk_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(eng_busy), .nv(eng_nv), .fall_stb(fall_stb), .cmd_bit(cmd_bit),
    .is_read(eng_is_read), .bit_idx(eng_idx)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int          rises = 0;
    int          oe_cnt = 0;
    logic [63:0] cap = '0;
    logic [15:0] phy_val = 16'h0;

    always #2 clk = ~clk;

    mdio_master dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model: capture on rising MDC, present read data after falling MDC
    always @(posedge mdc) begin
        #1;
        if (rises < 64) begin
            if (mdio_oe) begin
                cap[63 - rises] = mdio_o;
                oe_cnt = oe_cnt + 1;
            end
        end
        rises = rises + 1;
    end

    always @(negedge mdc) begin
        if (rises >= 48 && rises <= 63) mdio_i = phy_val[63 - rises];
        else mdio_i = 1'b1;
    end

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic mon_clear();
        rises = 0; oe_cnt = 0; cap = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic do_write(logic [2:0] sel, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [31:0] v;
        wr(3'd0, {29'd0, sel});
        wr(3'd2, {19'd0, p, 3'd0, r});
        mon_clear();
        wr(3'd3, {16'd0, d});
        rd(3'd5, v);
        chk("R5 busy after write launch, nv clear R6", {32'd0, v}, 64'd1);
        wait_idle();
        chk("R2/R1 write frame bits", cap, exp_frame(1'b0, p, r, d));
        chk("R2 driven bit count", 64'(oe_cnt), 64'd64);
        rd(3'd5, v);
        chk("R5 idle after write", {32'd0, v}, 64'd0);
    endtask

    task automatic do_read(logic [2:0] sel, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [31:0] v;
        logic [63:0] e;
        wr(3'd0, {29'd0, sel});
        wr(3'd2, {19'd0, p, 3'd0, r});
        wr(3'd1, 32'd0);
        phy_val = d;
        mon_clear();
        wr(3'd1, 32'd1);
        rd(3'd5, v);
        chk("R5/R6 busy and not-valid after read launch", {32'd0, v}, 64'd5);
        wait_idle();
        e = exp_frame(1'b1, p, r, 16'h0);
        chk("R3/R1 read header bits", {cap[63:18], 18'd0}, {e[63:18], 18'd0});
        chk("R4 released from turnaround", 64'(oe_cnt), 64'd46);
        rd(3'd4, v);
        chk("R4 read data", {32'd0, v}, {48'd0, d});
        rd(3'd5, v);
        chk("R6 flags clear after read", {32'd0, v}, 64'd0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(3'd0, v); chk("R9 config reset value", {32'd0, v}, 64'd7);
        rd(3'd5, v); chk("R9 indication reset", {32'd0, v}, 64'd0);
        chk("R9 mdc low, R7 line released", {62'd0, mdc, mdio_oe}, 64'd0);

        // directed frames
        do_write(3'd0, 5'h1F, 5'h00, 16'hA5C3);
        do_read(3'd0, 5'h01, 5'h1F, 16'h8001);
        do_write(3'd1, 5'h00, 5'h15, 16'hFFFF);

        // R3: rewrite 1 without clearing: no frame
        mon_clear();
        wr(3'd1, 32'd1);
        repeat (60) @(negedge clk);
        rd(3'd5, v);
        chk("R3 no relaunch on repeated 1", {32'd0, v}, 64'd0);
        chk("R3 no MDC activity", 64'(rises), 64'd0);

        // R7 half-period at two settings
        for (int s = 0; s < 4; s += 3) begin
            realtime t0, t1;
            wr(3'd0, 32'(s));
            mon_clear();
            wr(3'd3, 32'h1234);
            @(posedge mdc); t0 = $realtime;
            @(negedge mdc); t1 = $realtime;
            chk("R7 MDC high phase length", 64'(int'((t1 - t0) / 4.0)), 64'(4 * (s + 1)));
            @(posedge mdc); t0 = $realtime;
            chk("R7 MDC low phase length", 64'(int'((t0 - t1) / 4.0)), 64'(4 * (s + 1)));
            wait_idle();
        end

        // R8 abort mid-frame
        wr(3'd0, 32'd2);
        mon_clear();
        wr(3'd3, 32'hBEEF);
        wait (rises >= 20);
        wr(3'd0, 32'h8000_0000);
        rd(3'd5, v);
        chk("R8 flags clear after abort", {32'd0, v}, 64'd0);
        chk("R8 line released and MDC low", {62'd0, mdc, mdio_oe}, 64'd0);
        rd(3'd0, v);
        chk("R8 clock select kept", {32'd0, v}, 64'd2);

        // random mix
        for (int k = 0; k < 6; k++) begin
            logic [2:0]  s;
            logic [4:0]  p, r;
            logic [15:0] d;
            s = 3'($urandom_range(0, 2));
            p = 5'($urandom);
            r = 5'($urandom);
            d = 16'($urandom);
            if ($urandom_range(0, 1) == 1) do_read(s, p, r, d);
            else do_write(s, p, r, d);
        end

        // slowest setting once
        do_read(3'd7, 5'h0A, 5'h11, 16'h5A0F);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule